// File: doc/BRIEF.md
# I2S Master Bit-Clock and Word-Select Generator

This block derives the serial bit clock and the word-select (frame sync) of an I2S port acting as bus master from one system clock. Two small exponent codes set both ratios. A 3-bit bit-clock code `k` makes the bit clock run at the system clock divided by 2^(k+1), from 2 up to 256. A 3-bit frame code `f` makes one frame last 2^(f+3) bit clocks, from 8 up to 256. The frame may be longer than the data word, so the bit clock can be raised while the frame rate stays the same.

Both codes are captured when enable rises and stay fixed until the next enable. Changing the inputs while the block runs has no effect. Alongside the two clocks, the block gives a companion data shifter two strobes, each one system clock wide. The bit strobe fires in the cycle just before every bit-clock falling edge. The frame strobe fires on the strobe that opens a new frame. All outputs stay low while enable is low.

Top module: `i2s_clkgen`

## Requirements
- R1: `bclk_o` is a registered square wave with a period of 2^(k+1) system clocks and a 50% duty cycle, where k = `bclk_div_i` (0 to 7).
- R2: One frame lasts 2^(f+3) bit-clock periods for f = `frame_div_i` in 0 to 5. Frame length is counted in bit-clock falling edges between consecutive frame strobes.
- R3: Frame codes 6 and 7 behave as code 5, giving 256 bit clocks per frame.
- R4: `ws_o` is low for the first half of each frame and high for the second half. It changes level only on a bit-clock falling edge.
- R5: `bit_stb_o` is high for exactly one system clock, while `bclk_o` is high, and only in the cycle right before each falling edge of `bclk_o`.
- R6: `frame_stb_o` is high only together with `bit_stb_o`, before the falling edge that opens a frame, after which `ws_o` is low. The first bit-clock falling edge after enable opens a frame.
- R7: While `rst_ni` is low, and from the first clock edge that samples `en_i` low, `bclk_o`, `ws_o`, `bit_stb_o` and `frame_stb_o` are all low.
- R8: The codes are captured on the clock edge that first samples `en_i` high. Changes to `bclk_div_i` or `frame_div_i` while enabled do not alter the periods until enable is dropped and raised again.
- R9: After the edge that first samples `en_i` high, `bclk_o` starts low and first goes high 2^k system clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; its rising edge captures the codes |
| bclk_div_i | input | 3 | Bit-clock exponent k, divide by 2^(k+1) |
| frame_div_i | input | 3 | Frame exponent f, 2^(f+3) bit clocks per frame (6 and 7 clamp to 5) |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select / frame sync |
| bit_stb_o | output | 1 | One-cycle strobe before each bit-clock falling edge |
| frame_stb_o | output | 1 | One-cycle strobe before the falling edge that starts a frame |

## Verification
The bench targets the extreme codes.
- Divide-by-2 (k=0) leaves only one system clock per half period. A counter compare that is off by one there would stretch or never toggle the clock.
- Divide-by-256 exercises the widest counter.
- Frame codes 6 and 7 must clamp. Without the clamp, the frame length would wrap to a short or zero-length frame.

It also checks the start-up sequence and mid-run changes.
- The first rise of the bit clock must come exactly 2^k cycles after enable, and the first falling edge must carry a frame strobe. A design that started the frame counter at zero would skip that first strobe and shift word select by one bit.
- Codes changed mid-run must keep the old periods. A design that read its inputs live would show the new period at once.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int unsigned CDIV_W   = 3;
  localparam int unsigned FDIV_W   = 3;
  localparam int unsigned FDIV_MAX = 5;
endpackage

// File: rtl/i2s_cfg_latch.sv
module i2s_cfg_latch #(
  parameter int unsigned CDIV_W   = 3,
  parameter int unsigned FDIV_W   = 3,
  parameter int unsigned FDIV_MAX = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CDIV_W-1:0] cdiv_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  output logic              run_o,
  output logic              start_o,
  output logic [CDIV_W-1:0] cdiv_o,
  output logic [FDIV_W-1:0] fdiv_o
);
  localparam logic [FDIV_W-1:0] FMAX = FDIV_W'(FDIV_MAX);

  logic              run_q;
  logic [CDIV_W-1:0] cdiv_q;
  logic [FDIV_W-1:0] fdiv_q;
  logic [FDIV_W-1:0] fdiv_clamp;

  assign fdiv_clamp = (fdiv_i > FMAX) ? FMAX : fdiv_i;
  assign start_o    = en_i & ~run_q;
  assign run_o      = run_q;
  // pass new codes through in the start cycle so counters load consistently
  assign cdiv_o     = start_o ? cdiv_i : cdiv_q;
  assign fdiv_o     = start_o ? fdiv_clamp : fdiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cdiv_q <= '0;
      fdiv_q <= '0;
    end else begin
      run_q <= en_i;
      if (start_o) begin
        cdiv_q <= cdiv_i;
        fdiv_q <= fdiv_clamp;
      end
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(cdiv_q) && $stable(fdiv_q)));

  assert_fdiv_clamped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (fdiv_q <= FMAX));
endmodule

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int unsigned CDIV_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CDIV_W-1:0] cdiv_i,
  output logic              bclk_o,
  output logic              fall_pre_o
);
  localparam int unsigned CNT_W = (1 << CDIV_W) - 1;

  logic [CNT_W:0]   half;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;
  logic             tick;

  assign half       = {{CNT_W{1'b0}}, 1'b1} << cdiv_i;
  assign half_m1    = CNT_W'(half - 1'b1);
  assign tick       = (cnt_q == half_m1);
  assign bclk_o     = bclk_q;
  assign fall_pre_o = run_i & bclk_q & tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= half_m1));
endmodule

// File: rtl/i2s_frame_ctr.sv
module i2s_frame_ctr #(
  parameter int unsigned FDIV_W   = 3,
  parameter int unsigned FDIV_MAX = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  input  logic              fall_pre_i,
  output logic              ws_o,
  output logic              frame_pre_o
);
  localparam int unsigned BW = FDIV_MAX + 3;

  logic [BW:0]   len;
  logic [BW-1:0] len_m1;
  logic [BW-1:0] half_mask;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_nxt;
  logic          ws_q;
  logic          last;

  assign len         = {{BW{1'b0}}, 1'b1} << ((FDIV_W+1)'(fdiv_i) + (FDIV_W+1)'(3));
  assign len_m1      = BW'(len - 1'b1);
  assign half_mask   = BW'(len >> 1);
  assign last        = (cnt_q == len_m1);
  assign cnt_nxt     = last ? '0 : cnt_q + 1'b1;
  assign ws_o        = ws_q;
  assign frame_pre_o = fall_pre_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (start_i) begin
      // park on the last bit so the first falling edge opens a frame
      cnt_q <= len_m1;
      ws_q  <= 1'b0;
    end else if (fall_pre_i) begin
      cnt_q <= cnt_nxt;
      ws_q  <= |(cnt_nxt & half_mask);
    end
  end

  assert_frame_ws_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pre_o |=> !ws_q);
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned BCLK_DIV_W = CDIV_W,
  parameter int unsigned FRM_DIV_W  = FDIV_W,
  parameter int unsigned FRM_MAX    = FDIV_MAX
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [BCLK_DIV_W-1:0] bclk_div_i,
  input  logic [FRM_DIV_W-1:0]  frame_div_i,
  output logic                  bclk_o,
  output logic                  ws_o,
  output logic                  bit_stb_o,
  output logic                  frame_stb_o
);
  logic                  run;
  logic                  start;
  logic                  fall_pre;
  logic [BCLK_DIV_W-1:0] cdiv;
  logic [FRM_DIV_W-1:0]  fdiv;

  i2s_cfg_latch #(
    .CDIV_W  (BCLK_DIV_W),
    .FDIV_W  (FRM_DIV_W),
    .FDIV_MAX(FRM_MAX)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cdiv_i (bclk_div_i),
    .fdiv_i (frame_div_i),
    .run_o  (run),
    .start_o(start),
    .cdiv_o (cdiv),
    .fdiv_o (fdiv)
  );

  i2s_bclk_div #(
    .CDIV_W(BCLK_DIV_W)
  ) u_bclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clr_i     (~en_i | start),
    .cdiv_i    (cdiv),
    .bclk_o    (bclk_o),
    .fall_pre_o(fall_pre)
  );

  i2s_frame_ctr #(
    .FDIV_W  (FRM_DIV_W),
    .FDIV_MAX(FRM_MAX)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (start),
    .fdiv_i     (fdiv),
    .fall_pre_i (fall_pre),
    .ws_o       (ws_o),
    .frame_pre_o(frame_stb_o)
  );

  assign bit_stb_o = fall_pre;

  assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !ws_o && !bit_stb_o && !frame_stb_o));

  assert_stb_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> bclk_o);

  assert_stb_then_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bclk_o);

  assert_fall_has_stb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bclk_o) && $past(en_i)) |-> $past(bit_stb_o));

  assert_ws_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ws_o) && $past(en_i)) |-> $fell(bclk_o));

  assert_frame_in_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> bit_stb_o);
endmodule

// File: tb/i2s_clkgen_bench.sv
`timescale 1ns/1ps
module i2s_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] cd = '0;
  logic [2:0] fd = '0;
  logic       bclk, ws, bstb, fstb;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  i2s_clkgen u_i2s_clkgen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .bclk_div_i (cd),
    .frame_div_i(fd),
    .bclk_o     (bclk),
    .ws_o       (ws),
    .bit_stb_o  (bstb),
    .frame_stb_o(fstb)
  );

  // {k, f, bit-clock period, frame length}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 3'd0, 9'd2,   9'd8},
    {3'd1, 3'd0, 9'd4,   9'd8},
    {3'd2, 3'd1, 9'd8,   9'd16},
    {3'd5, 3'd1, 9'd64,  9'd16},
    {3'd7, 3'd1, 9'd256, 9'd16},
    {3'd3, 3'd2, 9'd16,  9'd32},
    {3'd0, 3'd3, 9'd2,   9'd64},
    {3'd1, 3'd4, 9'd4,   9'd128},
    {3'd0, 3'd5, 9'd2,   9'd256},
    {3'd0, 3'd6, 9'd2,   9'd256},
    {3'd1, 3'd7, 9'd4,   9'd256}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // samples outputs at falling clock edges for cyc cycles
  task automatic measure(input int cyc, output int period, output int high,
                         output int frame, output int half, output int bad_stb,
                         output int bad_ws, output int first_rise, output int ff_fs);
    logic pb, pw, pbs, pfs;
    int rise_t, falls, last_fs, ws_rise, hcnt;
    pb = bclk; pw = ws; pbs = bstb; pfs = fstb;
    period = -1; high = -1; frame = -1; half = -1; bad_stb = 0; bad_ws = 0;
    first_rise = -1; ff_fs = -1; rise_t = -1; falls = 0; last_fs = -1;
    ws_rise = -1; hcnt = 0;
    for (int k = 1; k <= cyc; k++) begin
      @(negedge clk);
      if (bclk && !pb) begin
        if (first_rise < 0) first_rise = k;
        if (rise_t >= 0 && period < 0) period = k - rise_t;
        rise_t = k;
        hcnt = 0;
      end
      if (bclk) hcnt++;
      if (!bclk && pb) begin
        if (!pbs) bad_stb++;
        if (high < 0) high = hcnt;
        falls++;
        if (ff_fs < 0) ff_fs = int'(pfs);
        if (pfs) begin
          if (ws) bad_ws++;
          if (last_fs >= 0 && frame < 0) frame = falls - last_fs;
          last_fs = falls;
        end
      end
      if (bstb && !bclk) bad_stb++;
      if (bstb && pbs) bad_stb++;
      if (fstb && !bstb) bad_stb++;
      if (ws != pw && !(!bclk && pb)) bad_ws++;
      if (ws && !pw) ws_rise = falls;
      if (!ws && pw && ws_rise >= 0 && half < 0) half = falls - ws_rise;
      pb = bclk; pw = ws; pbs = bstb; pfs = fstb;
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " bclk"}, int'(bclk), 0);
    chk({req, " ws"}, int'(ws), 0);
    chk({req, " bit_stb"}, int'(bstb), 0);
    chk({req, " frame_stb"}, int'(fstb), 0);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int p, h, fr, hf, bs, bw, fr1, ffs, k, f, ep, ef;
    repeat (3) @(negedge clk);
    chk_idle("R7 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R7 after reset");

    for (int i = 0; i < NV; i++) begin
      k  = int'(VEC[i][23:21]);
      f  = int'(VEC[i][20:18]);
      ep = int'(VEC[i][17:9]);
      ef = int'(VEC[i][8:0]);
      cd = VEC[i][23:21];
      fd = VEC[i][20:18];
      en = 1'b1;
      measure((ef + 2) * ep + 8, p, h, fr, hf, bs, bw, fr1, ffs);
      chk($sformatf("R1 period k=%0d", k), p, ep);
      chk($sformatf("R1 high time k=%0d", k), h, ep / 2);
      chk($sformatf("R9 first rise k=%0d", k), fr1, ep / 2 + 1);
      if (f > 5) chk($sformatf("R3 clamped frame f=%0d", f), fr, ef);
      else       chk($sformatf("R2 frame f=%0d", f), fr, ef);
      chk($sformatf("R4 ws high half f=%0d", f), hf, ef / 2);
      chk($sformatf("R4 ws edges f=%0d", f), bw, 0);
      chk($sformatf("R5 strobe alignment k=%0d", k), bs, 0);
      chk($sformatf("R6 first fall opens frame f=%0d", f), ffs, 1);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk_idle("R7 after disable");
      @(negedge clk);
    end

    // R7: disabled, inputs toggling, outputs stay low
    for (int j = 0; j < 40; j++) begin
      cd = 3'(j);
      fd = 3'(j + 3);
      @(negedge clk);
      if (j % 10 == 9) chk_idle("R7 disabled hold");
    end

    // R8: mid-run code change ignored
    cd = 3'd1; fd = 3'd0; en = 1'b1;
    repeat (20) @(negedge clk);
    cd = 3'd3; fd = 3'd2;
    measure(200, p, h, fr, hf, bs, bw, fr1, ffs);
    chk("R8 period held", p, 4);
    chk("R8 frame held", fr, 8);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    measure(34 * 16 + 8, p, h, fr, hf, bs, bw, fr1, ffs);
    chk("R8 new period after re-enable", p, 16);
    chk("R8 new frame after re-enable", fr, 32);

    // R7: drop enable while bit clock is high
    while (!bclk) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk_idle("R7 drop while high");

    // R7: async reset mid-run
    cd = 3'd0; fd = 3'd0; en = 1'b1;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R7 async reset");
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule